// File: doc/BRIEF.md
# Integer Execute ALU with Immediates and Product Registers

This block is the execute stage of a 32-bit load/store style integer core. Each cycle it takes an operation code, two register operands (`rs_i`, `rt_i`), a 16-bit immediate, a 5-bit shift amount and an immediate-select flag. The result and an overflow-exception flag come out combinationally in the same cycle.

The immediate-select flag replaces `rt_i` with the extended immediate for the add and logical operations. The operation decides how the immediate is extended: the add operations sign-extend it and the logical operations zero-extend it. Only the trapping add and subtract raise the exception flag. The other add and subtract variants wrap silently.

A signed 32x32 multiply writes its 64-bit product into a pair of product registers, high and low, on the rising clock edge. All other operations leave that pair untouched. The block has no state machine. Its only state is the product pair, which moves from holding to loaded only when the multiply code is present at a clock edge.

Top module: `mx_exec_alu`

## Requirements
- R1: Codes ADD=0 and ADDU=1 give `result_o` = operand A + operand B modulo 2^32, where operand A is `rs_i` and operand B is `rt_i` unless the immediate is selected.
- R2: ADD (code 0) raises `ovf_o` exactly when both operands have the same sign and the sum's sign differs from it. Operands of opposite sign never raise it.
- R3: ADDU (code 1) and SUBU (code 3) never raise `ovf_o`, whatever the operands.
- R4: SUB (code 2) and SUBU (code 3) give `rs_i` + (~`rt_i`) + 1 modulo 2^32. SUB raises `ovf_o` on signed overflow of that sum.
- R5: With `imm_sel_i`=1, ADD and ADDU use the 16-bit immediate sign-extended to 32 bits as operand B. ADD with the immediate still traps on overflow.
- R6: With `imm_sel_i`=1, AND=4, OR=5 and XOR=6 use the immediate zero-extended to 32 bits. With `imm_sel_i`=0 they combine `rs_i` and `rt_i` bitwise.
- R7: SLL=7 and SRL=8 shift `rt_i` by `shamt_i` with zero fill. SRA=9 shifts `rt_i` right with copies of bit 31.
- R8: A shift amount of 0 returns `rt_i` unchanged. SLL with `rt_i`=0 and `shamt_i`=0 acts as a no-op: `result_o`=0, `ovf_o`=0, and the product registers are unchanged.
- R9: MULT=10 loads the signed 64-bit product of `rs_i` and `rt_i` at the next rising edge, upper half in `hi_o` and lower half in `lo_o`. During MULT, `result_o` is 0 and `ovf_o` is 0.
- R10: Reset (active low) clears `hi_o` and `lo_o` to 0. At any edge where the code is not MULT, or while reset is held, both registers keep their value.
- R11: `imm_sel_i` has no effect on SUB, SUBU, the shifts or MULT. Codes 11 to 15 give `result_o`=0 and `ovf_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the product registers |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 4 | Operation code |
| imm_sel_i | input | 1 | Use the extended immediate as operand B |
| rs_i | input | 32 | Register operand A |
| rt_i | input | 32 | Register operand B and shift source |
| imm_i | input | 16 | Immediate field |
| shamt_i | input | 5 | Shift amount |
| result_o | output | 32 | Combinational result |
| ovf_o | output | 1 | Overflow exception flag |
| hi_o | output | 32 | Upper half of the last product |
| lo_o | output | 32 | Lower half of the last product |

## Verification
The clocked assertions sample the operation code and operands at the rising edge. They assume these inputs are settled there and change only between edges; the bench holds to this by driving every input on the falling edge. The hold check on the product registers also assumes that a non-multiply code present at one edge is what the registers last saw. The bench therefore keeps each operation in place for a full cycle before changing it. The stimulus also covers the sign-boundary operand pairs (0x7fffffff, 0x80000000, all ones), so the overflow properties are exercised at both of their edges.

// File: rtl/mx_alu_pkg.sv
package mx_alu_pkg;

    localparam int DATA_W  = 32;
    localparam int IMM_W   = 16;
    localparam int OP_W    = 4;
    localparam int SHAMT_W = $clog2(DATA_W);

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_ADDU = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBU = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_SLL  = 4'd7,
        OP_SRL  = 4'd8,
        OP_SRA  = 4'd9,
        OP_MULT = 4'd10
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RLOG  = 2'd1,
        SH_RARI  = 2'd2
    } shift_kind_e;

endpackage

// File: rtl/mx_imm_ext.sv
module mx_imm_ext #(
    parameter int IMM_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic [IMM_W-1:0]  imm,
    input  logic              sign_mode,
    output logic [DATA_W-1:0] ext
);
    localparam int PAD_W = DATA_W - IMM_W;

    logic pad_bit;

    always_comb begin
        pad_bit = sign_mode & imm[IMM_W-1];
        ext     = {{PAD_W{pad_bit}}, imm};
    end
endmodule

// File: rtl/mx_addsub.sv
module mx_addsub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    output logic [DATA_W-1:0] sum,
    output logic              sovf
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W-1:0] cin_vec;

    always_comb begin
        b_eff   = sub ? ~b : b;
        cin_vec = {{(DATA_W-1){1'b0}}, sub};
        sum     = a + b_eff + cin_vec;
        sovf    = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
    end
endmodule

// File: rtl/mx_shifter.sv
module mx_shifter
    import mx_alu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int SHAMT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0]  src,
    input  logic [SHAMT_W-1:0] amt,
    input  shift_kind_e        kind,
    output logic [DATA_W-1:0]  dst
);
    localparam int MSB = DATA_W - 1;

    logic              fill;
    logic              go_left;
    logic [DATA_W-1:0] rev_in;
    logic [DATA_W-1:0] stage [SHAMT_W+1];

    // Left shifts reuse the right-shifting ladder on bit-reversed data.
    always_comb begin
        go_left = (kind == SH_LEFT);
        fill    = (kind == SH_RARI) & src[MSB];
        for (int i = 0; i < DATA_W; i++) begin
            rev_in[i] = go_left ? src[MSB-i] : src[i];
        end
        stage[0] = rev_in;
    end

    for (genvar k = 0; k < SHAMT_W; k++) begin : g_rung
        localparam int D = 1 << k;
        always_comb begin
            if (amt[k]) begin
                stage[k+1] = {{D{fill}}, stage[k][MSB:D]};
            end else begin
                stage[k+1] = stage[k];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            dst[i] = go_left ? stage[SHAMT_W][MSB-i] : stage[SHAMT_W][i];
        end
    end
endmodule

// File: rtl/mx_prod_regs.sv
module mx_prod_regs #(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DATA_W-1:0]   rs,
    input  logic [DATA_W-1:0]   rt,
    input  logic                load,
    output logic [DATA_W-1:0]   hi,
    output logic [DATA_W-1:0]   lo
);
    localparam int PROD_W = 2 * DATA_W;

    logic signed [PROD_W-1:0] prod;

    always_comb begin
        prod = PROD_W'($signed(rs)) * PROD_W'($signed(rt));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi <= '0;
            lo <= '0;
        end else if (load) begin
            hi <= prod[PROD_W-1:DATA_W];
            lo <= prod[DATA_W-1:0];
        end
    end
endmodule

// File: rtl/mx_exec_alu.sv
module mx_exec_alu
    import mx_alu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [OP_W-1:0]      op_i,
    input  logic                 imm_sel_i,
    input  logic [DATA_W-1:0]    rs_i,
    input  logic [DATA_W-1:0]    rt_i,
    input  logic [IMM_W-1:0]     imm_i,
    input  logic [SHAMT_W-1:0]   shamt_i,
    output logic [DATA_W-1:0]    result_o,
    output logic                 ovf_o,
    output logic [DATA_W-1:0]    hi_o,
    output logic [DATA_W-1:0]    lo_o
);
    localparam int MSB = DATA_W - 1;

    alu_op_e           op;
    logic              imm_allowed;
    logic              use_imm;
    logic              ext_signed;
    logic              do_sub;
    logic              traps;
    logic              mult_sel;
    shift_kind_e       sh_kind;
    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] opnd_b;
    logic [DATA_W-1:0] arith_sum;
    logic              arith_ovf;
    logic [DATA_W-1:0] shift_out;

    // Decode
    always_comb begin
        op          = alu_op_e'(op_i);
        imm_allowed = 1'b0;
        ext_signed  = 1'b0;
        do_sub      = 1'b0;
        traps       = 1'b0;
        mult_sel    = 1'b0;
        sh_kind     = SH_LEFT;
        unique case (op)
            OP_ADD:  begin imm_allowed = 1'b1; ext_signed = 1'b1; traps = 1'b1; end
            OP_ADDU: begin imm_allowed = 1'b1; ext_signed = 1'b1; end
            OP_SUB:  begin do_sub = 1'b1; traps = 1'b1; end
            OP_SUBU: begin do_sub = 1'b1; end
            OP_AND, OP_OR, OP_XOR: imm_allowed = 1'b1;
            OP_SRL:  sh_kind  = SH_RLOG;
            OP_SRA:  sh_kind  = SH_RARI;
            OP_MULT: mult_sel = 1'b1;
            default: ;
        endcase
        use_imm = imm_allowed & imm_sel_i;
    end

    mx_imm_ext #(.IMM_W(IMM_W), .DATA_W(DATA_W)) u_ext (
        .imm       (imm_i),
        .sign_mode (ext_signed),
        .ext       (imm_ext)
    );

    always_comb opnd_b = use_imm ? imm_ext : rt_i;

    mx_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a    (rs_i),
        .b    (opnd_b),
        .sub  (do_sub),
        .sum  (arith_sum),
        .sovf (arith_ovf)
    );

    mx_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shift (
        .src  (rt_i),
        .amt  (shamt_i),
        .kind (sh_kind),
        .dst  (shift_out)
    );

    mx_prod_regs #(.DATA_W(DATA_W)) u_prod (
        .clk   (clk),
        .rst_n (rst_n),
        .rs    (rs_i),
        .rt    (rt_i),
        .load  (mult_sel),
        .hi    (hi_o),
        .lo    (lo_o)
    );

    // Result select
    always_comb begin
        result_o = '0;
        unique case (op)
            OP_ADD, OP_ADDU, OP_SUB, OP_SUBU: result_o = arith_sum;
            OP_AND:                           result_o = rs_i & opnd_b;
            OP_OR:                            result_o = rs_i | opnd_b;
            OP_XOR:                           result_o = rs_i ^ opnd_b;
            OP_SLL, OP_SRL, OP_SRA:           result_o = shift_out;
            default:                          result_o = '0;
        endcase
        ovf_o = traps & arith_ovf;
    end

    // Checks on the ports
    a_r2_opposite_signs_safe: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd0 && !imm_sel_i && rs_i[MSB] != rt_i[MSB]) |-> !ovf_o);

    a_r2_same_sign_flip_traps: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd0 && !imm_sel_i && rs_i[MSB] == rt_i[MSB] && result_o[MSB] != rs_i[MSB]) |-> ovf_o);

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd1 || op_i == 4'd3) |-> !ovf_o);

    a_r6_zero_ext_and: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd4 && imm_sel_i) |-> (result_o[MSB:IMM_W] == '0));

    a_r7_sra_sign_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd9 && rt_i[MSB]) |-> result_o[MSB]);

    a_r7_srl_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd8 && shamt_i != '0) |-> !result_o[MSB]);

    a_r8_shift_zero_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i >= 4'd7 && op_i <= 4'd9 && shamt_i == '0) |-> (result_o == rt_i));

    a_r8_noop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd7 && rt_i == '0 && shamt_i == '0) |-> (result_o == '0 && !ovf_o));

    a_r9_mult_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd10) |-> (result_o == '0 && !ovf_o));

    a_r10_prod_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != 4'd10) |=> ($stable(hi_o) && $stable(lo_o)));

    a_r11_undef_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i > 4'd10) |-> (result_o == '0 && !ovf_o));

endmodule

// File: tb/mx_exec_alu_bench.sv
module mx_exec_alu_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 26;

    typedef struct packed {
        logic [3:0]  op;
        logic        isel;
        logic [31:0] a;
        logic [31:0] b;
        logic [15:0] imm;
        logic [4:0]  sh;
        logic [31:0] res;
        logic        ovf;
        logic [7:0]  req;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{4'd0, 1'b0, 32'h7fffffff, 32'h00000001, 16'h0, 5'd0, 32'h80000000, 1'b1, 8'd2},  // R2
        '{4'd1, 1'b0, 32'h7fffffff, 32'h00000001, 16'h0, 5'd0, 32'h80000000, 1'b0, 8'd3},  // R3
        '{4'd0, 1'b0, 32'hffffffed, 32'hfffffff9, 16'h0, 5'd0, 32'hffffffe6, 1'b0, 8'd1},  // R1
        '{4'd0, 1'b0, 32'h80000000, 32'hffffffff, 16'h0, 5'd0, 32'h7fffffff, 1'b1, 8'd2},  // R2
        '{4'd0, 1'b0, 32'h80000000, 32'h7fffffff, 16'h0, 5'd0, 32'hffffffff, 1'b0, 8'd2},  // R2
        '{4'd1, 1'b0, 32'h80000000, 32'h80000000, 16'h0, 5'd0, 32'h00000000, 1'b0, 8'd3},  // R3
        '{4'd2, 1'b0, 32'h80000000, 32'h00000001, 16'h0, 5'd0, 32'h7fffffff, 1'b1, 8'd4},  // R4
        '{4'd3, 1'b0, 32'h80000000, 32'h00000001, 16'h0, 5'd0, 32'h7fffffff, 1'b0, 8'd3},  // R3
        '{4'd2, 1'b0, 32'h00000005, 32'h00000007, 16'h0, 5'd0, 32'hfffffffe, 1'b0, 8'd4},  // R4
        '{4'd0, 1'b1, 32'h00000010, 32'h12345678, 16'hfff0, 5'd0, 32'h00000000, 1'b0, 8'd5},  // R5
        '{4'd0, 1'b1, 32'h7fffffff, 32'h00000000, 16'h0001, 5'd0, 32'h80000000, 1'b1, 8'd5},  // R5
        '{4'd1, 1'b1, 32'h7fffffff, 32'h00000000, 16'h8000, 5'd0, 32'h7fff7fff, 1'b0, 8'd5},  // R5
        '{4'd4, 1'b1, 32'hffffffff, 32'h00000000, 16'h8001, 5'd0, 32'h00008001, 1'b0, 8'd6},  // R6
        '{4'd5, 1'b1, 32'h12340000, 32'hffffffff, 16'hff00, 5'd0, 32'h1234ff00, 1'b0, 8'd6},  // R6
        '{4'd6, 1'b1, 32'hffff0000, 32'h00000000, 16'hffff, 5'd0, 32'hffffffff, 1'b0, 8'd6},  // R6
        '{4'd4, 1'b0, 32'hf0f0f0f0, 32'hff00ff00, 16'h0, 5'd0, 32'hf000f000, 1'b0, 8'd6},  // R6
        '{4'd5, 1'b0, 32'h0f0f0000, 32'h0000f0f0, 16'h0, 5'd0, 32'h0f0ff0f0, 1'b0, 8'd6},  // R6
        '{4'd6, 1'b0, 32'haaaaaaaa, 32'hffffffff, 16'h0, 5'd0, 32'h55555555, 1'b0, 8'd6},  // R6
        '{4'd7, 1'b0, 32'hffffffff, 32'h00000001, 16'h0, 5'd31, 32'h80000000, 1'b0, 8'd7},  // R7
        '{4'd8, 1'b0, 32'h00000000, 32'h80000000, 16'h0, 5'd4, 32'h08000000, 1'b0, 8'd7},  // R7
        '{4'd9, 1'b0, 32'h00000000, 32'h80000000, 16'h0, 5'd4, 32'hf8000000, 1'b0, 8'd7},  // R7
        '{4'd9, 1'b0, 32'h00000000, 32'h7ffffff0, 16'h0, 5'd4, 32'h07ffffff, 1'b0, 8'd7},  // R7
        '{4'd7, 1'b0, 32'h00000000, 32'hdeadbeef, 16'h0, 5'd0, 32'hdeadbeef, 1'b0, 8'd8},  // R8
        '{4'd9, 1'b0, 32'h00000000, 32'hdeadbeef, 16'h0, 5'd0, 32'hdeadbeef, 1'b0, 8'd8},  // R8
        '{4'd2, 1'b1, 32'h00000005, 32'h00000003, 16'hffff, 5'd0, 32'h00000002, 1'b0, 8'd11}, // R11
        '{4'd15, 1'b0, 32'h12345678, 32'h9abcdef0, 16'h0, 5'd3, 32'h00000000, 1'b0, 8'd11}  // R11
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = 4'd0;
    logic        imm_sel_i = 1'b0;
    logic [31:0] rs_i = '0;
    logic [31:0] rt_i = '0;
    logic [15:0] imm_i = '0;
    logic [4:0]  shamt_i = '0;
    logic [31:0] result_o;
    logic        ovf_o;
    logic [31:0] hi_o;
    logic [31:0] lo_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mx_exec_alu u_mx_exec_alu (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (op_i),
        .imm_sel_i (imm_sel_i),
        .rs_i      (rs_i),
        .rt_i      (rt_i),
        .imm_i     (imm_i),
        .shamt_i   (shamt_i),
        .result_o  (result_o),
        .ovf_o     (ovf_o),
        .hi_o      (hi_o),
        .lo_o      (lo_o)
    );

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] op, input logic isel, input logic [31:0] a,
                         input logic [31:0] b, input logic [15:0] imm, input logic [4:0] sh);
        @(negedge clk);
        op_i = op; imm_sel_i = isel; rs_i = a; rt_i = b; imm_i = imm; shamt_i = sh;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R10: a multiply during reset must not load the product pair
        drive(4'd10, 1'b0, 32'h00000003, 32'h00000005, 16'h0, 5'd0);
        @(posedge clk); @(posedge clk); #1;
        check32("R10 reset hi", hi_o, 32'h0);
        check32("R10 reset lo", lo_o, 32'h0);
        drive(4'd0, 1'b0, 32'h0, 32'h0, 16'h0, 5'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].op, VECS[i].isel, VECS[i].a, VECS[i].b, VECS[i].imm, VECS[i].sh);
            n_chk++;
            if (result_o !== VECS[i].res || ovf_o !== VECS[i].ovf) begin
                n_bad++;
                $display("FAIL R%0d vector %0d: got %h/%b expected %h/%b", VECS[i].req, i,
                         result_o, ovf_o, VECS[i].res, VECS[i].ovf);
            end
        end

        // R9: signed product of -2 and 3, result port quiet
        drive(4'd10, 1'b1, 32'hfffffffe, 32'h00000003, 16'hffff, 5'd7);
        check32("R9 mult result", result_o, 32'h0);
        check32("R9 mult ovf", {31'd0, ovf_o}, 32'h0);
        @(posedge clk); #1;
        check32("R9 hi", hi_o, 32'hffffffff);
        check32("R9 lo", lo_o, 32'hfffffffa);

        // R9: carry into upper half
        drive(4'd10, 1'b0, 32'h00010000, 32'h00010000, 16'h0, 5'd0);
        @(posedge clk); #1;
        check32("R9 hi carry", hi_o, 32'h00000001);
        check32("R9 lo carry", lo_o, 32'h00000000);

        // R10: a non-multiply operation leaves the pair alone
        drive(4'd0, 1'b0, 32'h11111111, 32'h22222222, 16'h0, 5'd0);
        @(posedge clk); #1;
        check32("R10 hold hi", hi_o, 32'h00000001);
        check32("R10 hold lo", lo_o, 32'h00000000);

        // R8: no-op shift encoding
        drive(4'd7, 1'b0, 32'h0, 32'h0, 16'h0, 5'd0);
        check32("R8 noop result", result_o, 32'h0);
        check32("R8 noop ovf", {31'd0, ovf_o}, 32'h0);
        @(posedge clk); #1;
        check32("R8 noop hi", hi_o, 32'h00000001);
        check32("R8 noop lo", lo_o, 32'h00000000);

        // R7: full-width arithmetic shift of a negative value
        drive(4'd9, 1'b0, 32'h0, 32'h80000001, 16'h0, 5'd31);
        check32("R7 sra 31", result_o, 32'hffffffff);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule